// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block times the clock line of an I2C master. A prescaler divides the system clock into a sampling tick. The bus clock is then built from a low phase and a high phase, and each phase lasts a programmed number of sampling ticks. Each phase length is taken from a 16-bit timing word that holds two 8-bit counts. The lower count is used for standard and fast operation and for the master-code part of a high-speed transfer. The upper count is used for the high-speed data part that follows.

The byte engine that sits beside this generator raises `run` to start clocking and lowers it to stop. In high-speed mode, it pulses `hs_switch` once the master code has been acknowledged. The generator gives the byte engine two pulses. `shift_tick` comes at the middle of each low phase, when SDA may change. `sample_tick` comes at the middle of each high phase, when SDA is read.

Top module: `scl_phase_gen`

## Requirements
- R1: The sampling tick occurs once every `psc`+1 system clock cycles while the generator runs. With `psc` held constant, each phase therefore lasts a whole multiple of (`psc`+1) cycles.
- R2: A low phase lasts (low count + 7) sampling ticks and a high phase lasts (high count + 5) sampling ticks. Each count is an 8-bit value from 0 to 255, so a phase lasts 7..262 or 5..260 ticks.
- R3: In mode 2'b00 (standard), 2'b01 (fast) or 2'b11 (treated as fast), only bits [7:0] of each timing word are used. Bits [15:8] have no effect, `hs_switch` is ignored and `hs_active` stays 0.
- R4: In mode 2'b10 (high-speed), bits [7:0] of each timing word are used until `hs_switch` is sampled high. After that, `hs_active` is 1 and bits [15:8] are used. The phase that is in progress when the strobe arrives keeps its length, and the new lengths take effect from the next phase boundary.
- R5: When `run` is sampled low, the clock line is released (`scl_drive_low` = 0) in the next cycle and both tick outputs stay 0. `hs_active` returns to 0, so the next run starts again on bits [7:0].
- R6: When `run` is sampled high while the generator is idle, a fresh low phase of full length begins in the next cycle. The phase always restarts from the beginning, even if the previous run was stopped partway through a high phase.
- R7: `shift_tick` pulses for one cycle in the low phase on sampling tick number floor(L/2), counting from 0. This is cycle floor(L/2)*(`psc`+1)+`psc` of the phase, where L is the low length in ticks. `sample_tick` behaves the same way in the high phase, using the high length.
- R8: During reset, `scl_drive_low`, `shift_tick`, `sample_tick` and `hs_active` are all 0, whatever the value of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to generate the clock, low to stop and release the line |
| mode | input | 2 | Bus speed: 00 standard, 01 fast, 10 high-speed, 11 fast |
| psc | input | 8 | Prescaler; sampling tick every psc+1 cycles |
| low_word | input | 16 | Low-phase counts: [7:0] first pair, [15:8] high-speed pair |
| high_word | input | 16 | High-phase counts: [7:0] first pair, [15:8] high-speed pair |
| hs_switch | input | 1 | One-cycle strobe that selects the high-speed pair |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| shift_tick | output | 1 | Pulse in the middle of the low phase |
| sample_tick | output | 1 | Pulse in the middle of the high phase |
| hs_active | output | 1 | High-speed pair is in use |

## Verification
The main function is tried with five timing settings. These differ in prescaler value (0 to 3), in count values (including the minimum of 0 and the maximum of 255), and in upper-byte contents that must be ignored. The measured low and high phase lengths tell apart an off-by-one error in the prescaler, a wrong offset, and use of the wrong byte. The positions of the mid-phase ticks separate the cases of even and odd phase lengths. Directed runs then cover the high-speed switch arriving mid-phase, stopping and restarting during a high phase, and a switch strobe that is ignored in fast mode.

// File: rtl/scl_gen_pkg.sv
// Package: shared encodings for the clock phase timing generator.
// Assumes: mode values are driven by the byte engine as listed below.
package scl_gen_pkg;

    typedef enum logic [1:0] {
        SPD_STD  = 2'b00,
        SPD_FAST = 2'b01,
        SPD_HS   = 2'b10,
        SPD_RSV  = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_HIGH = 2'b10
    } phase_e;

endpackage

// File: rtl/scl_tick_div.sv
// Module: scl_tick_div
// Divides the system clock into a one-cycle sampling tick every psc+1 cycles.
// Assumes: psc is held steady while en is high; en low holds the count at 0,
// so the first tick after enabling comes psc+1 cycles later.
module scl_tick_div #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam logic [PSC_W-1:0] PC_ONE = PSC_W'(1);

    logic [PSC_W-1:0] pc;

    // Tick when the count has reached the divide limit.
    assign tick = en && (pc >= psc);

    // Count cycles between ticks, restarting on every tick or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc <= '0;
        else if (!en || tick) pc <= '0;
        else                 pc <= pc + PC_ONE;
    end

    // R1: with a nonzero, steady divide, two ticks are never adjacent.
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (psc != '0)) |=> (!tick || (psc != $past(psc))));

endmodule

// File: rtl/scl_pair_sel.sv
// Module: scl_pair_sel
// Chooses which byte of each timing word is active, and adds the fixed phase
// offsets. It tracks the high-speed phase flag, which is set by the switch
// strobe and cleared by stop or by leaving high-speed mode.
// Assumes: words pack the first pair in the low byte and the high-speed pair
// in the high byte.
module scl_pair_sel
    import scl_gen_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5,
    parameter int LEN_W    = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  speed_e             mode,
    input  logic               hs_switch,
    input  logic [2*CNT_W-1:0] low_word,
    input  logic [2*CNT_W-1:0] high_word,
    output logic [LEN_W-1:0]   low_len,
    output logic [LEN_W-1:0]   high_len,
    output logic               hs_phase
);
    logic             use_hi;
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;

    // Set the high-speed flag on the strobe; clear it on stop or mode change.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hs_phase <= 1'b0;
        else if (!run || mode != SPD_HS)  hs_phase <= 1'b0;
        else if (hs_switch)               hs_phase <= 1'b1;
    end

    assign use_hi = hs_phase && (mode == SPD_HS);

    // Pick the active byte of each word.
    always_comb begin
        low_cnt  = use_hi ? low_word[2*CNT_W-1:CNT_W]  : low_word[CNT_W-1:0];
        high_cnt = use_hi ? high_word[2*CNT_W-1:CNT_W] : high_word[CNT_W-1:0];
    end

    // Phase lengths in ticks: count plus fixed offset.
    always_comb begin
        low_len  = LEN_W'(low_cnt)  + LEN_W'(LOW_OFS);
        high_len = LEN_W'(high_cnt) + LEN_W'(HIGH_OFS);
    end

    // R3: outside high-speed mode the second pair is never selected.
    assert_no_hs_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != SPD_HS) |=> !hs_phase);

    // R4: once selected, the second pair stays while running in high-speed mode.
    assert_hs_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_phase && run && mode == SPD_HS) |=> hs_phase);

    // R5: a stop returns to the first pair.
    assert_stop_reverts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !hs_phase);

endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Steps the clock through low and high phases, counting sampling ticks.
// A phase length is latched on entry to the phase, so a change in the
// selected pair only takes effect at the next phase boundary. Mid-phase
// pulses come from the tick count.
// Assumes: lengths are at least 2 ticks.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic             running,
    output logic             scl_low,
    output logic             shift_tick,
    output logic             sample_tick
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    phase_e           state;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             last_tick;

    assign last_tick = tick && (cnt == cur_len - ONE);

    // Phase state, tick count within the phase and latched phase length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PH_IDLE;
            cnt     <= '0;
            cur_len <= '0;
        end else if (!run) begin
            state <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PH_IDLE: begin
                    state   <= PH_LOW;
                    cnt     <= '0;
                    cur_len <= low_len;
                end
                PH_LOW: begin
                    if (last_tick) begin
                        state   <= PH_HIGH;
                        cnt     <= '0;
                        cur_len <= high_len;
                    end else if (tick) begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_HIGH: begin
                    if (last_tick) begin
                        state   <= PH_LOW;
                        cnt     <= '0;
                        cur_len <= low_len;
                    end else if (tick) begin
                        cnt <= cnt + ONE;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign running = (state != PH_IDLE);
    assign scl_low = (state == PH_LOW);

    // Mid-phase pulses on tick number floor(len/2).
    always_comb begin
        shift_tick  = (state == PH_LOW)  && tick && (cnt == (cur_len >> 1));
        sample_tick = (state == PH_HIGH) && tick && (cnt == (cur_len >> 1));
    end

    // R2: the tick count stays inside the latched phase length.
    assert_cnt_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < cur_len));

endmodule

// File: rtl/scl_phase_gen.sv
// Module: scl_phase_gen (top)
// Clock phase timing generator for an I2C master: a prescaler, a timing pair
// selector and a phase sequencer.
// Assumes: psc and the timing words are steady while run is high; hs_switch
// is a one-cycle strobe from the byte engine.
module scl_phase_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [1:0]         mode,
    input  logic [PSC_W-1:0]   psc,
    input  logic [2*CNT_W-1:0] low_word,
    input  logic [2*CNT_W-1:0] high_word,
    input  logic               hs_switch,
    output logic               scl_drive_low,
    output logic               shift_tick,
    output logic               sample_tick,
    output logic               hs_active
);
    localparam int LEN_W = CNT_W + 1;

    logic             tick;
    logic             running;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;

    scl_tick_div #(.PSC_W(PSC_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .psc   (psc),
        .tick  (tick)
    );

    scl_pair_sel #(
        .CNT_W    (CNT_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS),
        .LEN_W    (LEN_W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .mode      (speed_e'(mode)),
        .hs_switch (hs_switch),
        .low_word  (low_word),
        .high_word (high_word),
        .low_len   (low_len),
        .high_len  (high_len),
        .hs_phase  (hs_active)
    );

    scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .tick        (tick),
        .low_len     (low_len),
        .high_len    (high_len),
        .running     (running),
        .scl_low     (scl_drive_low),
        .shift_tick  (shift_tick),
        .sample_tick (sample_tick)
    );

    // R5: a stop releases the line in the next cycle.
    assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_drive_low && !shift_tick && !sample_tick));

    // R6: a start from idle begins with the line pulled low.
    assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |=> scl_drive_low);

    // R7: each mid-phase pulse belongs to its own phase, and they never coincide.
    assert_mid_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_tick |-> (scl_drive_low && !sample_tick)) and
        (sample_tick |-> !scl_drive_low));

endmodule

// File: tb/scl_phase_gen_tb_top.sv
`timescale 1ns/1ps
module scl_phase_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  psc = 8'd0;
    logic [15:0] low_word = 16'h0;
    logic [15:0] high_word = 16'h0;
    logic        hs_switch = 1'b0;
    logic        scl_drive_low, shift_tick, sample_tick, hs_active;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam int MAXW = 3000;
    localparam int NVEC = 5;
    // mode, psc, low_word, high_word, low cycles, high cycles, shift pos, sample pos
    localparam int VEC [NVEC][8] = '{
        '{0, 0, 'h0003, 'h0002,  10,  7,   5,  3},
        '{1, 3, 'hAA01, 'h5500,  32, 20,  19, 11},
        '{0, 1, 'h0000, 'h0000,  14, 10,   7,  5},
        '{2, 2, 'h0102, 'h0301,  27, 18,  14, 11},
        '{1, 0, 'h00FF, 'h0000, 262,  5, 131,  2}
    };

    always #2 clk = ~clk;

    scl_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .psc(psc),
        .low_word(low_word), .high_word(high_word), .hs_switch(hs_switch),
        .scl_drive_low(scl_drive_low), .shift_tick(shift_tick),
        .sample_tick(sample_tick), .hs_active(hs_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive negedge samples with the line at level v; note the
    // first mid-phase pulse position inside that run of samples.
    task automatic count_level(input logic v, output int n, output int pos);
        n = 0;
        pos = -1;
        while (scl_drive_low == v && n < MAXW) begin
            if (pos < 0 && (v ? shift_tick : sample_tick)) pos = n;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic start_run(input int m, input int p, input int lw, input int hw);
        mode = 2'(m); psc = 8'(p); low_word = 16'(lw); high_word = 16'(hw);
        run = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int n, pos;
        // R8: reset dominates even with run high
        run = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 scl", int'(scl_drive_low), 0);
        chk("R8 ticks", int'(shift_tick | sample_tick), 0);
        chk("R8 hs", int'(hs_active), 0);
        run = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1, R2, R3 (upper bytes ignored), R7
        for (int i = 0; i < NVEC; i++) begin
            start_run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            count_level(1'b1, n, pos);
            chk($sformatf("R1 R2 low length vec%0d", i), n, VEC[i][4]);
            chk($sformatf("R7 shift pos vec%0d", i), pos, VEC[i][6]);
            count_level(1'b0, n, pos);
            chk($sformatf("R1 R2 high length vec%0d", i), n, VEC[i][5]);
            chk($sformatf("R7 sample pos vec%0d", i), pos, VEC[i][7]);
        end

        // R4: high-speed switch mid low phase
        start_run(2, 0, 'h0402, 'h0301);
        count_level(1'b1, n, pos);
        chk("R4 first low", n, 9);
        count_level(1'b0, n, pos);
        chk("R4 first high", n, 6);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        count_level(1'b1, n, pos);
        chk("R4 low in progress keeps length", n, 8);
        chk("R4 hs_active", int'(hs_active), 1);
        count_level(1'b0, n, pos);
        chk("R4 hs high", n, 8);
        count_level(1'b1, n, pos);
        chk("R4 hs low", n, 11);

        // R5: stop releases and reverts to first pair
        run = 1'b0;
        @(negedge clk);
        chk("R5 released", int'(scl_drive_low), 0);
        chk("R5 hs cleared", int'(hs_active), 0);
        repeat (3) @(negedge clk);
        chk("R5 no ticks", int'(shift_tick | sample_tick | scl_drive_low), 0);
        run = 1'b1;
        @(negedge clk);
        count_level(1'b1, n, pos);
        chk("R5 R6 restart on first pair", n, 9);

        // R3: switch strobe ignored in fast mode
        start_run(1, 0, 'h0402, 'h0301);
        count_level(1'b1, n, pos);
        count_level(1'b0, n, pos);
        hs_switch = 1'b1;
        @(negedge clk);
        hs_switch = 1'b0;
        count_level(1'b1, n, pos);
        chk("R3 low after ignored strobe", n, 8);
        chk("R3 hs_active stays 0", int'(hs_active), 0);
        count_level(1'b0, n, pos);
        chk("R3 high unchanged", n, 6);
        count_level(1'b1, n, pos);
        chk("R3 next low unchanged", n, 9);

        // R6: stop in the high phase, restart with a full low phase
        run = 1'b0;
        @(negedge clk);
        chk("R6 released before restart", int'(scl_drive_low), 0);
        run = 1'b1;
        @(negedge clk);
        chk("R6 low right after start", int'(scl_drive_low), 1);
        count_level(1'b1, n, pos);
        chk("R6 full low after restart", n, 9);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule